// File: doc/BRIEF.md
# Cascaded Interrupt Controller

This block gathers interrupt requests for a processor. Up to 32 main sources are latched into a source-pending register, and 11 sub-sources are latched into a sub-pending register. The sub-sources fall into four groups: three groups of three (one per serial port) and one group of two (analog converter and touch panel). Each group has its own sub-pending and sub-mask bits and folds into one main source. A main-mask register decides which latched main sources may compete. Among the unmasked pending ones, the controller picks exactly one. It records the pick as a one-hot interrupt-pending word with a matching index register, and holds its single IRQ line high while that word is nonzero.

Software reaches the six registers over a simple single-cycle register bus. Word addresses: 0 source-pending, 1 main mask, 2 interrupt-pending, 3 index (read only), 4 sub-pending, 5 sub-mask. A service routine reads the index. It then clears the bit in source-pending and then the same bit in interrupt-pending, each by writing a word with a 1 in that bit position. If a sub-source is behind the main bit, the routine clears the sub-pending bit first. Once interrupt-pending is empty, the controller arbitrates again and raises the next request.

Top module: `casc_irq_ctrl`

## Requirements
- R1: After reset, source-pending, interrupt-pending, sub-pending and the index read 0. The main mask reads 0xFFFFFFFF, the sub-mask reads 0x7FF, and irq is low.
- R2: A pulse on src_evt[n] sets source-pending bit n at the next clock edge, whatever the mask holds. A main source whose mask bit is 1 never reaches interrupt-pending.
- R3: When interrupt-pending is zero and unmasked sources are pending, the lowest-numbered one wins on the next edge. Interrupt-pending then holds only that bit, and the index register holds its number.
- R4: Interrupt-pending and the index change to a new source only while interrupt-pending is zero. A lower-numbered source arriving later does not preempt the current one.
- R5: irq is high exactly while interrupt-pending is nonzero.
- R6: Writing a word to source-pending (address 0) or interrupt-pending (address 2) clears exactly the bits that are 1 in that word. All other bits are unchanged.
- R7: Once the serviced bit is cleared from source-pending and then from interrupt-pending, the next pending unmasked source is raised one edge later.
- R8: A pulse on sub_evt[i] sets sub-pending bit i at the next edge. While that bit is set and sub-mask bit i is 0, the bit sets its group's main source-pending bit on every following edge. Groups: sub 0–2 go to main 28, 3–5 to main 23, 6–8 to main 15, 9–10 to main 31. A sub-source whose sub-mask bit is 1 does not affect source-pending.
- R9: Writing a word to sub-pending (address 4) clears only the sub-pending bits that are 1 in that word.
- R10: The main mask (address 1) reads back all 32 written bits. The sub-mask (address 5) keeps the low 11 bits of the written word and reads 0 above them.
- R11: If an event and a clear write hit the same pending bit in one cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | 32 | Main source requests, one bit per source |
| sub_evt | input | 11 | Sub-source requests, one bit per sub-source |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that software is the only thing that empties interrupt-pending. They also assume that a new pick never starts from a nonzero interrupt-pending word, so once irq rises the index is expected to stay put until the word is empty. The bench keeps inside this by always servicing in the stated order: sub-pending first, then source-pending, then interrupt-pending. It also drives every input on the falling clock edge and pulses each event for exactly one cycle.

// File: rtl/casc_irq_ctrl.sv
module casc_irq_ctrl #(
  parameter int NUM_SRC   = 32,
  parameter int NUM_SUB   = 11,
  parameter int UART0_SRC = 28,
  parameter int UART1_SRC = 23,
  parameter int UART2_SRC = 15,
  parameter int ADC_SRC   = 31
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_evt,
  input  logic [NUM_SUB-1:0] sub_evt,
  input  logic               bus_wr,
  input  logic [2:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq
);
  localparam int OFF_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] src_pend, mask, int_pend;
  logic [NUM_SUB-1:0] sub_pend, sub_mask;
  logic [OFF_W-1:0]   offset;

  logic [NUM_SRC-1:0] cand, fold;
  logic [NUM_SUB-1:0] sub_act;
  logic [OFF_W-1:0]   win;

  function automatic logic [OFF_W-1:0] sub_main(input int i);
    if (i < 3)      return OFF_W'(UART0_SRC);
    else if (i < 6) return OFF_W'(UART1_SRC);
    else if (i < 9) return OFF_W'(UART2_SRC);
    else            return OFF_W'(ADC_SRC);
  endfunction

  wire wr_src  = bus_wr && bus_addr == 3'd0;
  wire wr_mask = bus_wr && bus_addr == 3'd1;
  wire wr_int  = bus_wr && bus_addr == 3'd2;
  wire wr_sub  = bus_wr && bus_addr == 3'd4;
  wire wr_smsk = bus_wr && bus_addr == 3'd5;

  assign sub_act = sub_pend & ~sub_mask;
  assign cand    = src_pend & ~mask;
  assign irq     = |int_pend;

  always_comb begin
    fold = '0;
    for (int i = 0; i < NUM_SUB; i++)
      if (sub_act[i]) fold[sub_main(i)] = 1'b1;
  end

  always_comb begin
    win = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (cand[i]) win = OFF_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_pend <= '0;
      mask     <= '1;
      int_pend <= '0;
      offset   <= '0;
      sub_pend <= '0;
      sub_mask <= '1;
    end else begin
      src_pend <= (src_pend & ~(wr_src ? bus_wdata[NUM_SRC-1:0] : '0)) | src_evt | fold;
      sub_pend <= (sub_pend & ~(wr_sub ? bus_wdata[NUM_SUB-1:0] : '0)) | sub_evt;
      if (wr_mask) mask <= bus_wdata[NUM_SRC-1:0];
      if (wr_smsk) sub_mask <= bus_wdata[NUM_SUB-1:0];
      if (int_pend == '0) begin
        if (|cand) begin
          int_pend <= cand & (~cand + 1'b1);
          offset   <= win;
        end
      end else if (wr_int) begin
        int_pend <= int_pend & ~bus_wdata[NUM_SRC-1:0];
      end
    end
  end

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = 32'(src_pend);
      3'd1:    bus_rdata = 32'(mask);
      3'd2:    bus_rdata = 32'(int_pend);
      3'd3:    bus_rdata = 32'(offset);
      3'd4:    bus_rdata = 32'(sub_pend);
      3'd5:    bus_rdata = 32'(sub_mask);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/casc_irq_ctrl_chk.sv
module casc_irq_ctrl_chk #(
  parameter int NSRC = 32,
  parameter int NSUB = 11,
  parameter int OW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq,
  input logic [NSRC-1:0] src_pend,
  input logic [NSRC-1:0] mask,
  input logic [NSRC-1:0] int_pend,
  input logic [OW-1:0]   offset,
  input logic [NSUB-1:0] sub_pend,
  input logic [NSUB-1:0] sub_evt
);
  // R3
  onehot_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(int_pend));

  // R3
  offset_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> int_pend[offset]);

  // R2
  unmasked_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ((($past(src_pend & ~mask)) >> offset) & NSRC'(1)) == NSRC'(1));

  // R3
  lowest_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(src_pend & ~mask) & ((NSRC'(1) << offset) - NSRC'(1))) == '0);

  // R4
  hold_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(int_pend) != '0) |-> (offset == $past(offset)));

  // R8
  sub_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_pend & ~$past(sub_pend) & ~$past(sub_evt)) == '0);
endmodule

bind casc_irq_ctrl casc_irq_ctrl_chk #(.NSRC(NUM_SRC), .NSUB(NUM_SUB), .OW(OFF_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq(irq), .src_pend(src_pend), .mask(mask),
  .int_pend(int_pend), .offset(offset), .sub_pend(sub_pend), .sub_evt(sub_evt)
);

// File: tb/casc_irq_ctrl_test.sv
module casc_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_evt = '0;
  logic [10:0] sub_evt = '0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0, failures = 0;
  bit done = 0;

  casc_irq_ctrl uut (.*);

  always #10 clk = ~clk;

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_reg(input string req, input logic [2:0] a, input logic [31:0] exp);
    bus_addr = a; #1;
    check(req, $sformatf("reg%0d", a), bus_rdata, exp);
  endtask

  task automatic pulse_src(input logic [31:0] b);
    src_evt = b; tick(); src_evt = '0;
  endtask

  task automatic pulse_sub(input logic [10:0] b);
    sub_evt = b; tick(); sub_evt = '0;
  endtask

  function automatic int grp_main(input int i);
    if (i < 3) return 28;
    if (i < 6) return 23;
    if (i < 9) return 15;
    return 31;
  endfunction

  task automatic t_reset;
    chk_reg("R1", 3'd0, 32'h0);
    chk_reg("R1", 3'd1, 32'hFFFF_FFFF);
    chk_reg("R1", 3'd2, 32'h0);
    chk_reg("R1", 3'd3, 32'h0);
    chk_reg("R1", 3'd4, 32'h0);
    chk_reg("R1", 3'd5, 32'h7FF);
    check("R1", "irq", 32'(irq), 32'h0);
  endtask

  task automatic t_regs;
    wr(3'd1, 32'h1234_5678);
    chk_reg("R10", 3'd1, 32'h1234_5678);
    wr(3'd5, 32'hFFFF_F0F0);
    chk_reg("R10", 3'd5, 32'h0000_00F0);
    wr(3'd5, 32'h7FF);
    wr(3'd1, 32'hFFFF_FFFF);
  endtask

  task automatic t_mask;
    pulse_src(32'h20);
    chk_reg("R2", 3'd0, 32'h20);
    tick(3);
    check("R2", "irq masked", 32'(irq), 32'h0);
    chk_reg("R2", 3'd2, 32'h0);
    wr(3'd1, ~32'h20);
    check("R5", "irq before pick", 32'(irq), 32'h0);
    tick();
    check("R5", "irq after pick", 32'(irq), 32'h1);
    chk_reg("R3", 3'd2, 32'h20);
    chk_reg("R3", 3'd3, 32'd5);
    wr(3'd0, 32'h20);
    wr(3'd2, 32'h20);
    check("R5", "irq cleared", 32'(irq), 32'h0);
    tick(2);
    check("R7", "stays idle", 32'(irq), 32'h0);
  endtask

  task automatic t_priority;
    wr(3'd1, 32'h0);
    pulse_src(32'h0010_0200);
    tick();
    chk_reg("R3", 3'd3, 32'd9);
    pulse_src(32'h8);
    tick(2);
    chk_reg("R4", 3'd3, 32'd9);
    chk_reg("R4", 3'd2, 32'h200);
    wr(3'd0, 32'h200);
    chk_reg("R6", 3'd0, 32'h0010_0008);
    wr(3'd2, 32'h0);
    chk_reg("R6", 3'd2, 32'h200);
    wr(3'd2, 32'h200);
    tick();
    chk_reg("R7", 3'd3, 32'd3);
    wr(3'd0, 32'h8);
    wr(3'd2, 32'h8);
    tick();
    chk_reg("R7", 3'd3, 32'd20);
    wr(3'd0, 32'h0010_0000);
    wr(3'd2, 32'h0010_0000);
    tick();
    check("R7", "all serviced", 32'(irq), 32'h0);
  endtask

  task automatic t_setclr;
    pulse_src(32'h80);
    tick();
    bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 32'h80; src_evt = 32'h80;
    tick();
    bus_wr = 1'b0; bus_wdata = '0; src_evt = '0;
    chk_reg("R11", 3'd0, 32'h80);
    wr(3'd0, 32'h80);
    wr(3'd2, 32'h80);
    tick();
    chk_reg("R11", 3'd0, 32'h0);
  endtask

  task automatic t_sub_mask;
    pulse_sub(11'h010);
    chk_reg("R8", 3'd4, 32'h010);
    tick(3);
    chk_reg("R8", 3'd0, 32'h0);
    wr(3'd5, 32'h7EF);
    tick();
    chk_reg("R8", 3'd0, 32'h0080_0000);
    tick();
    chk_reg("R8", 3'd3, 32'd23);
    wr(3'd4, 32'h010);
    wr(3'd0, 32'h0080_0000);
    wr(3'd2, 32'h0080_0000);
    tick();
    chk_reg("R8", 3'd0, 32'h0);
    check("R8", "irq idle", 32'(irq), 32'h0);
    wr(3'd5, 32'h7FF);
    pulse_sub(11'h003);
    wr(3'd4, 32'h001);
    chk_reg("R9", 3'd4, 32'h002);
    wr(3'd4, 32'h002);
    chk_reg("R9", 3'd4, 32'h0);
  endtask

  task automatic t_sub_groups;
    wr(3'd5, 32'h0);
    for (int i = 0; i < 11; i++) begin
      pulse_sub(11'(1 << i));
      tick(2);
      chk_reg("R8", 3'd3, 32'(grp_main(i)));
      wr(3'd4, 32'(1 << i));
      wr(3'd0, 32'h1 << grp_main(i));
      wr(3'd2, 32'h1 << grp_main(i));
      tick();
      check("R8", $sformatf("sub %0d serviced", i), 32'(irq), 32'h0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_regs();
    t_mask();
    t_priority();
    t_setclr();
    t_sub_mask();
    t_sub_groups();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule